// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block sits behind a clock generator and decides, output by output, whether each generated clock reaches its pin. It gates four families of raw clocks: several differential CPU pairs, one differential SRC pair, free-running and stoppable PCI-class single-ended outputs, and reference outputs. Two events stop clocks. The first is an asynchronous active-low power-down pin. The second is a software run bit that, when cleared, stops every output marked stoppable. Configuration bits pick, for each output, whether it is enabled, whether the software stop applies to it, and whether a stopped differential output keeps driving or releases its pins.

Every single-ended and SRC output stops low at a falling edge of its own source clock. It resumes only at a rising edge, so no pulse is shorter than half a source period. The power-down pin is filtered on the rising edges of the CPU complement clock. While powered down, the CPU pairs park with the true leg driven high and the complement leg undriven, not low.

Top module: `clkstop_ctrl`

## Requirements
- R1: Power-down takes effect only after `pd_n` is sampled low on two consecutive rising edges of the CPU complement clock, which are the falling edges of `cpu_clk`. A low seen on only one such edge changes no output.
- R2: While powered down, every PCIF, PCI and REF output is held low, and the SRC pair rests with `src_t` low and `src_c` high.
- R3: While powered down, every CPU pair parks with `cpu_t` at 1 and `cpu_c_oe` at 0. `cpu_t_oe[i]` is 0 when `cpu_tri_pd[i]` is 1, and 1 otherwise, provided the pair is enabled.
- R4: No gated output shows a high or low phase shorter than half the period of its source clock, including across every stop and every restart.
- R5: With `sw_run` = 0, all PCI outputs stop. Each PCIF output with `pcif_stoppable[i]` = 1 stops, and the SRC pair stops when `src_stoppable` = 1. A PCIF output with `pcif_stoppable[i]` = 0, and every REF output, keep toggling.
- R6: `src_oe` is 0 while the SRC pair is stopped by power-down and `src_tri_pd` = 1, or while it is stopped by the software stop and `src_tri_stop` = 1. Otherwise it equals `src_en`.
- R7: An enable bit of 0 holds a single-ended output low. A CPU or SRC enable bit of 0 drives both output-enables of that pair to 0.
- R8: After reset, with `pd_n` = 1, `sw_run` = 1 and all enables at 1, every output toggles and every output-enable is 1.
- R9: When power-down or the software stop ends, each stopped output toggles again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, sampled in each clock domain |
| cpu_clk | input | 1 | Raw CPU clock; its falling edge is the complement rising edge |
| src_clk | input | 1 | Raw SRC clock |
| pci_clk | input | 1 | Raw clock shared by PCIF and PCI outputs |
| ref_clk | input | 1 | Raw reference clock |
| pd_n | input | 1 | Asynchronous power-down request, active low |
| sw_run | input | 1 | Software run bit; 0 stops the stoppable outputs |
| cpu_en | input | N_CPU | Per-pair CPU enable |
| cpu_tri_pd | input | N_CPU | Per-pair: 1 releases the true leg too in power-down |
| src_en | input | 1 | SRC pair enable |
| src_stoppable | input | 1 | 1 makes SRC follow the software stop |
| src_tri_pd | input | 1 | 1 releases SRC pins while stopped by power-down |
| src_tri_stop | input | 1 | 1 releases SRC pins while stopped by software |
| pcif_en | input | N_PCIF | Per-output PCIF enable |
| pcif_stoppable | input | N_PCIF | Per-output: 1 makes PCIF follow the software stop |
| pci_en | input | N_PCI | Per-output PCI enable |
| ref_en | input | N_REF | Per-output REF enable |
| cpu_t | output | N_CPU | CPU true legs |
| cpu_c | output | N_CPU | CPU complement legs |
| cpu_t_oe | output | N_CPU | Output-enable of the true legs |
| cpu_c_oe | output | N_CPU | Output-enable of the complement legs |
| src_t | output | 1 | SRC true leg |
| src_c | output | 1 | SRC complement leg |
| src_oe | output | 1 | Output-enable of the SRC pair |
| pcif_o | output | N_PCIF | Gated PCIF clocks |
| pci_o | output | N_PCI | Gated PCI clocks |
| ref_o | output | N_REF | Gated REF clocks |

## Verification
Power-down is recognised on the second low-sampling falling edge of `cpu_clk`. The CPU pairs park at the next rising edge of `cpu_clk`. Every other output parks at the first falling edge of its own clock that follows two of its own rising edges, and so at most three of its own periods later. Software stops and enable changes take the same route through the per-output synchroniser. The bench therefore changes inputs and waits well beyond three periods of the slowest clock before it counts rising edges in a fixed window and samples levels. The one-edge power-down pulse is placed between rising edges of `cpu_clk` so that exactly one falling edge sees it.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;

    // Reasons an output may be held; each bit is synchronised separately
    typedef enum logic [1:0] {
        REQ_PD  = 2'd0,
        REQ_SW  = 2'd1,
        REQ_OFF = 2'd2
    } stop_reason_e;

    localparam int NREQ = 3;

    typedef logic [NREQ-1:0] stop_vec_t;

    function automatic stop_vec_t mk_req(input logic pd, input logic sw, input logic off);
        stop_vec_t r;
        r          = '0;
        r[REQ_PD]  = pd;
        r[REQ_SW]  = sw;
        r[REQ_OFF] = off;
        return r;
    endfunction

    // Output enable of a differential leg given which reasons hold it
    function automatic logic diff_oe(input logic en, input stop_vec_t held,
                                     input logic tri_pd, input logic tri_sw);
        return en & ~(held[REQ_PD] & tri_pd) & ~(held[REQ_SW] & tri_sw);
    endfunction

endpackage

// File: rtl/clkstop_pd_detect.sv
`timescale 1ns/1ps
module clkstop_pd_detect (
    input  logic cpu_clk,
    input  logic rst,
    input  logic pd_n,
    output logic pd_act,
    output logic cpu_park
);
    logic prev_n_q;

    // Complement rising edge == falling edge of the true clock
    always_ff @(negedge cpu_clk) begin
        if (rst) begin
            prev_n_q <= 1'b1;
            pd_act   <= 1'b0;
        end else begin
            prev_n_q <= pd_n;
            pd_act   <= ~(prev_n_q | pd_n);
        end
    end

    // Park the true leg at its own rising edge, so it never dips
    always_ff @(posedge cpu_clk) begin
        if (rst) cpu_park <= 1'b0;
        else     cpu_park <= pd_act;
    end
endmodule

// File: rtl/clkstop_stop_cell.sv
`timescale 1ns/1ps
module clkstop_stop_cell
    import clkstop_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  stop_vec_t req,
    output stop_vec_t held
);
    stop_vec_t meta_q;
    stop_vec_t sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= req;
            sync_q <= meta_q;
        end
    end

    // Updated while the source is low: stop at a fall, resume before a rise
    always_ff @(negedge clk) begin
        if (rst) held <= '0;
        else     held <= sync_q;
    end
endmodule

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/1ps
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int N_CPU  = 3,
    parameter int N_PCIF = 3,
    parameter int N_PCI  = 6,
    parameter int N_REF  = 2
) (
    input  logic              rst,
    input  logic              cpu_clk,
    input  logic              src_clk,
    input  logic              pci_clk,
    input  logic              ref_clk,
    input  logic              pd_n,
    input  logic              sw_run,
    input  logic [N_CPU-1:0]  cpu_en,
    input  logic [N_CPU-1:0]  cpu_tri_pd,
    input  logic              src_en,
    input  logic              src_stoppable,
    input  logic              src_tri_pd,
    input  logic              src_tri_stop,
    input  logic [N_PCIF-1:0] pcif_en,
    input  logic [N_PCIF-1:0] pcif_stoppable,
    input  logic [N_PCI-1:0]  pci_en,
    input  logic [N_REF-1:0]  ref_en,
    output logic [N_CPU-1:0]  cpu_t,
    output logic [N_CPU-1:0]  cpu_c,
    output logic [N_CPU-1:0]  cpu_t_oe,
    output logic [N_CPU-1:0]  cpu_c_oe,
    output logic              src_t,
    output logic              src_c,
    output logic              src_oe,
    output logic [N_PCIF-1:0] pcif_o,
    output logic [N_PCI-1:0]  pci_o,
    output logic [N_REF-1:0]  ref_o
);
    logic pd_act;
    logic cpu_park;
    logic sw_stop;

    assign sw_stop = ~sw_run;

    clkstop_pd_detect u_pd (
        .cpu_clk  (cpu_clk),
        .rst      (rst),
        .pd_n     (pd_n),
        .pd_act   (pd_act),
        .cpu_park (cpu_park)
    );

    // CPU pairs: one park flop shared, per-pair enables and release choice
    for (genvar g = 0; g < N_CPU; g++) begin : g_cpu
        assign cpu_t[g]    = cpu_clk | cpu_park;
        assign cpu_c[g]    = ~cpu_clk & ~cpu_park;
        assign cpu_t_oe[g] = diff_oe(cpu_en[g], mk_req(cpu_park, 1'b0, 1'b0), cpu_tri_pd[g], 1'b0);
        assign cpu_c_oe[g] = cpu_en[g] & ~cpu_park;
    end

    // SRC pair
    stop_vec_t src_held;
    clkstop_stop_cell u_src (
        .clk  (src_clk),
        .rst  (rst),
        .req  (mk_req(pd_act, sw_stop & src_stoppable, 1'b0)),
        .held (src_held)
    );
    assign src_t  = src_clk & ~|src_held;
    assign src_c  = ~src_t;
    assign src_oe = diff_oe(src_en, src_held, src_tri_pd, src_tri_stop);

    // PCIF: software stop only where marked stoppable
    for (genvar g = 0; g < N_PCIF; g++) begin : g_pcif
        stop_vec_t held;
        clkstop_stop_cell u_cell (
            .clk  (pci_clk),
            .rst  (rst),
            .req  (mk_req(pd_act, sw_stop & pcif_stoppable[g], ~pcif_en[g])),
            .held (held)
        );
        assign pcif_o[g] = pci_clk & ~|held;
    end

    // PCI: always follows the software stop
    for (genvar g = 0; g < N_PCI; g++) begin : g_pci
        stop_vec_t held;
        clkstop_stop_cell u_cell (
            .clk  (pci_clk),
            .rst  (rst),
            .req  (mk_req(pd_act, sw_stop, ~pci_en[g])),
            .held (held)
        );
        assign pci_o[g] = pci_clk & ~|held;
    end

    // REF: power-down and enable only
    for (genvar g = 0; g < N_REF; g++) begin : g_ref
        stop_vec_t held;
        clkstop_stop_cell u_cell (
            .clk  (ref_clk),
            .rst  (rst),
            .req  (mk_req(pd_act, 1'b0, ~ref_en[g])),
            .held (held)
        );
        assign ref_o[g] = ref_clk & ~|held;
    end
endmodule

// File: rtl/clkstop_ctrl_chk.sv
`timescale 1ns/1ps
module clkstop_ctrl_chk #(
    parameter int N_CPU = 3,
    parameter int N_PCI = 6,
    parameter int N_REF = 2
) (
    input logic             rst,
    input logic             cpu_clk,
    input logic             src_clk,
    input logic             pci_clk,
    input logic             ref_clk,
    input logic             pd_n,
    input logic             pd_act,
    input logic             sw_run,
    input logic             src_tri_pd,
    input logic [N_CPU-1:0] cpu_t,
    input logic [N_CPU-1:0] cpu_c_oe,
    input logic             src_oe,
    input logic [N_PCI-1:0] pci_o,
    input logic [N_REF-1:0] ref_o
);
    logic [2:0] pci_age, ref_age, src_age;

    always_ff @(negedge pci_clk) begin
        if (rst) pci_age <= '0;
        else if (pci_age != 3'd4) pci_age <= pci_age + 3'd1;
    end
    always_ff @(negedge ref_clk) begin
        if (rst) ref_age <= '0;
        else if (ref_age != 3'd4) ref_age <= ref_age + 3'd1;
    end
    always_ff @(negedge src_clk) begin
        if (rst) src_age <= '0;
        else if (src_age != 3'd4) src_age <= src_age + 3'd1;
    end

    // R1: power-down begins only after two consecutive low samples
    a_r1_two_low_samples: assert property (@(negedge cpu_clk) disable iff (rst)
        $rose(pd_act) |-> (!$past(pd_n) && !$past(pd_n, 2)));

    // R3: CPU pairs parked true-high, complement released
    a_r3_cpu_parked: assert property (@(posedge cpu_clk) disable iff (rst)
        $past(pd_act) |-> ((&cpu_t) && (cpu_c_oe == '0)));

    // R5: PCI outputs low through a held software stop
    a_r5_pci_sw_stop: assert property (@(negedge pci_clk) disable iff (rst)
        (pci_age == 3'd4 && !sw_run && !$past(sw_run) && !$past(sw_run, 2) && !$past(sw_run, 3))
        |-> (pci_o == '0));

    // R2: REF outputs low through a held power-down
    a_r2_ref_pd_low: assert property (@(negedge ref_clk) disable iff (rst)
        (ref_age == 3'd4 && pd_act && $past(pd_act) && $past(pd_act, 2) && $past(pd_act, 3))
        |-> (ref_o == '0));

    // R6: SRC released in power-down when so configured
    a_r6_src_tri_pd: assert property (@(negedge src_clk) disable iff (rst)
        (src_age == 3'd4 && src_tri_pd && pd_act && $past(pd_act) && $past(pd_act, 2) && $past(pd_act, 3))
        |-> !src_oe);
endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(.N_CPU(N_CPU), .N_PCI(N_PCI), .N_REF(N_REF)) u_chk (
    .rst        (rst),
    .cpu_clk    (cpu_clk),
    .src_clk    (src_clk),
    .pci_clk    (pci_clk),
    .ref_clk    (ref_clk),
    .pd_n       (pd_n),
    .pd_act     (pd_act),
    .sw_run     (sw_run),
    .src_tri_pd (src_tri_pd),
    .cpu_t      (cpu_t),
    .cpu_c_oe   (cpu_c_oe),
    .src_oe     (src_oe),
    .pci_o      (pci_o),
    .ref_o      (ref_o)
);

// File: tb/tb_clkstop_ctrl.sv
`timescale 1ns/1ps
module tb_edge_mon #(parameter int HALF = 4) (
    input  logic sig,
    output int   rises,
    output int   runts
);
    int  n_rise = 0;
    int  n_hi   = 0;
    int  n_lo   = 0;
    time t_rise = 0;
    time t_fall = 0;
    bit  seen_r = 0;
    bit  seen_f = 0;

    always @(posedge sig) begin
        if (seen_f && ($time - t_fall) < HALF) n_lo++;
        t_rise = $time;
        seen_r = 1;
        n_rise++;
    end
    always @(negedge sig) begin
        if (seen_r && ($time - t_rise) < HALF) n_hi++;
        t_fall = $time;
        seen_f = 1;
    end
    assign rises = n_rise;
    assign runts = n_hi + n_lo;
endmodule

module tb_clkstop_ctrl;
    localparam int CPU_PERIOD = 8;
    localparam int SRC_PERIOD = 10;
    localparam int PCI_PERIOD = 30;
    localparam int REF_PERIOD = 70;
    localparam int N_CPU = 3, N_PCIF = 3, N_PCI = 6, N_REF = 2;
    localparam int SETTLE = 1200;
    localparam int WINDOW = 1400;

    logic cpu_clk = 0, src_clk = 0, pci_clk = 0, ref_clk = 0;
    logic rst = 1, pd_n = 1, sw_run = 1;
    logic [N_CPU-1:0]  cpu_en = '1, cpu_tri_pd = '0;
    logic src_en = 1, src_stoppable = 0, src_tri_pd = 0, src_tri_stop = 0;
    logic [N_PCIF-1:0] pcif_en = '1, pcif_stoppable = '0;
    logic [N_PCI-1:0]  pci_en = '1;
    logic [N_REF-1:0]  ref_en = '1;
    logic [N_CPU-1:0]  cpu_t, cpu_c, cpu_t_oe, cpu_c_oe;
    logic src_t, src_c, src_oe;
    logic [N_PCIF-1:0] pcif_o;
    logic [N_PCI-1:0]  pci_o;
    logic [N_REF-1:0]  ref_o;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #(CPU_PERIOD/2) cpu_clk = ~cpu_clk;
    initial begin #3; forever #(SRC_PERIOD/2) src_clk = ~src_clk; end
    initial begin #7; forever #(PCI_PERIOD/2) pci_clk = ~pci_clk; end
    initial begin #11; forever #(REF_PERIOD/2) ref_clk = ~ref_clk; end

    clkstop_ctrl #(.N_CPU(N_CPU), .N_PCIF(N_PCIF), .N_PCI(N_PCI), .N_REF(N_REF)) dut (
        .rst(rst), .cpu_clk(cpu_clk), .src_clk(src_clk), .pci_clk(pci_clk), .ref_clk(ref_clk),
        .pd_n(pd_n), .sw_run(sw_run), .cpu_en(cpu_en), .cpu_tri_pd(cpu_tri_pd),
        .src_en(src_en), .src_stoppable(src_stoppable), .src_tri_pd(src_tri_pd),
        .src_tri_stop(src_tri_stop), .pcif_en(pcif_en), .pcif_stoppable(pcif_stoppable),
        .pci_en(pci_en), .ref_en(ref_en), .cpu_t(cpu_t), .cpu_c(cpu_c),
        .cpu_t_oe(cpu_t_oe), .cpu_c_oe(cpu_c_oe), .src_t(src_t), .src_c(src_c),
        .src_oe(src_oe), .pcif_o(pcif_o), .pci_o(pci_o), .ref_o(ref_o)
    );

    int cpu_r [N_CPU];  int cpu_u [N_CPU];
    int pcif_r[N_PCIF]; int pcif_u[N_PCIF];
    int pci_r [N_PCI];  int pci_u [N_PCI];
    int ref_r [N_REF];  int ref_u [N_REF];
    int src_r, src_u;

    for (genvar g = 0; g < N_CPU; g++) begin : g_mc
        tb_edge_mon #(.HALF(CPU_PERIOD/2)) u_m (.sig(cpu_t[g]), .rises(cpu_r[g]), .runts(cpu_u[g]));
    end
    for (genvar g = 0; g < N_PCIF; g++) begin : g_mf
        tb_edge_mon #(.HALF(PCI_PERIOD/2)) u_m (.sig(pcif_o[g]), .rises(pcif_r[g]), .runts(pcif_u[g]));
    end
    for (genvar g = 0; g < N_PCI; g++) begin : g_mp
        tb_edge_mon #(.HALF(PCI_PERIOD/2)) u_m (.sig(pci_o[g]), .rises(pci_r[g]), .runts(pci_u[g]));
    end
    for (genvar g = 0; g < N_REF; g++) begin : g_mr
        tb_edge_mon #(.HALF(REF_PERIOD/2)) u_m (.sig(ref_o[g]), .rises(ref_r[g]), .runts(ref_u[g]));
    end
    tb_edge_mon #(.HALF(SRC_PERIOD/2)) u_msrc (.sig(src_t), .rises(src_r), .runts(src_u));

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected-stop functions straight from the requirements
    function automatic bit pd_on();                 return !pd_n; endfunction
    function automatic bit sw_on();                 return !sw_run; endfunction
    function automatic bit src_stop_exp();          return pd_on() || (sw_on() && src_stoppable); endfunction
    function automatic bit pcif_stop_exp(int i);    return pd_on() || !pcif_en[i] || (sw_on() && pcif_stoppable[i]); endfunction
    function automatic bit pci_stop_exp(int i);     return pd_on() || !pci_en[i] || sw_on(); endfunction
    function automatic bit ref_stop_exp(int i);     return pd_on() || !ref_en[i]; endfunction
    function automatic string why(bit en);
        if (pd_on()) return "R2";
        if (!en)     return "R7";
        if (sw_on()) return "R5";
        return "R9";
    endfunction

    task automatic check_running(input bit stop, input int d, input logic lvl, input string req, input string what);
        if (stop) chk(d == 0 && lvl == 1'b0, req, {what, " stopped low"}, d, 0);
        else      chk(d > 0, req, {what, " toggling"}, d, 1);
    endtask

    task automatic check_all();
        int c0[N_CPU]; int f0[N_PCIF]; int p0[N_PCI]; int r0[N_REF]; int s0;
        #(SETTLE);
        c0 = cpu_r; f0 = pcif_r; p0 = pci_r; r0 = ref_r; s0 = src_r;
        #(WINDOW);
        for (int i = 0; i < N_CPU; i++) begin
            if (pd_on()) chk(cpu_r[i] == c0[i] && cpu_t[i] == 1'b1, "R3", "cpu true parked high", cpu_r[i]-c0[i], 0);
            else         chk(cpu_r[i] > c0[i], "R9", "cpu true toggling", cpu_r[i]-c0[i], 1);
            chk(cpu_c_oe[i] == (cpu_en[i] && !pd_on()), pd_on() ? "R3" : "R7", "cpu_c_oe",
                int'(cpu_c_oe[i]), int'(cpu_en[i] && !pd_on()));
            chk(cpu_t_oe[i] == (cpu_en[i] && !(pd_on() && cpu_tri_pd[i])), pd_on() ? "R3" : "R7", "cpu_t_oe",
                int'(cpu_t_oe[i]), int'(cpu_en[i] && !(pd_on() && cpu_tri_pd[i])));
        end
        check_running(src_stop_exp(), src_r - s0, src_t, pd_on() ? "R2" : (sw_on() ? "R5" : "R9"), "src_t");
        if (src_stop_exp()) chk(src_c == 1'b1, "R2", "src_c rests high", int'(src_c), 1);
        chk(src_oe == (src_en && !(pd_on() && src_tri_pd) && !(sw_on() && src_stoppable && src_tri_stop)),
            "R6", "src_oe", int'(src_oe),
            int'(src_en && !(pd_on() && src_tri_pd) && !(sw_on() && src_stoppable && src_tri_stop)));
        for (int i = 0; i < N_PCIF; i++)
            check_running(pcif_stop_exp(i), pcif_r[i] - f0[i], pcif_o[i], why(pcif_en[i]), $sformatf("pcif_o[%0d]", i));
        for (int i = 0; i < N_PCI; i++)
            check_running(pci_stop_exp(i), pci_r[i] - p0[i], pci_o[i], why(pci_en[i]), $sformatf("pci_o[%0d]", i));
        for (int i = 0; i < N_REF; i++)
            check_running(ref_stop_exp(i), ref_r[i] - r0[i], ref_o[i], why(ref_en[i]), $sformatf("ref_o[%0d]", i));
    endtask

    initial begin
        int seed_dummy;
        int c0;
        seed_dummy = $urandom(32'h5EED_C10C);
        #1000;
        rst = 0;
        // R8: reset state, all running, all enables on
        check_all();
        chk(&cpu_t_oe && &cpu_c_oe && src_oe, "R8", "oe after reset", int'({cpu_t_oe, cpu_c_oe, src_oe}), -1 >>> 0);

        // R1: a low seen by a single complement edge is ignored
        @(posedge cpu_clk); #1 pd_n = 0;
        @(posedge cpu_clk); #1 pd_n = 1;
        c0 = cpu_r[0];
        #(200);
        chk(cpu_r[0] > c0 && &cpu_c_oe, "R1", "single low sample ignored", cpu_r[0] - c0, 1);

        // R1/R3: two consecutive low samples park the CPU pairs
        cpu_tri_pd = 3'b010;
        @(posedge cpu_clk); #1 pd_n = 0;
        @(posedge cpu_clk); @(posedge cpu_clk); #1;
        chk(cpu_c_oe == '0, "R1", "two low samples park", int'(cpu_c_oe), 0);
        check_all();
        // R9: release
        pd_n = 1;
        check_all();

        // R5: directed software stop with mixed stoppable marks
        pcif_stoppable = 3'b101; src_stoppable = 1; src_tri_stop = 1; sw_run = 0;
        check_all();
        sw_run = 1;
        check_all();

        // R7: disables
        cpu_en = 3'b110; src_en = 0; pci_en = 6'b111110; ref_en = 2'b01;
        check_all();

        // Constrained random mix
        for (int it = 0; it < 30; it++) begin
            pd_n           = ($urandom % 4) != 0;
            sw_run         = $urandom % 2;
            cpu_tri_pd     = N_CPU'($urandom);
            src_stoppable  = $urandom % 2;
            src_tri_pd     = $urandom % 2;
            src_tri_stop   = $urandom % 2;
            src_en         = ($urandom % 4) != 0;
            pcif_stoppable = N_PCIF'($urandom);
            for (int i = 0; i < N_CPU; i++)  cpu_en[i]  = ($urandom % 4) != 0;
            for (int i = 0; i < N_PCIF; i++) pcif_en[i] = ($urandom % 4) != 0;
            for (int i = 0; i < N_PCI; i++)  pci_en[i]  = ($urandom % 4) != 0;
            for (int i = 0; i < N_REF; i++)  ref_en[i]  = ($urandom % 4) != 0;
            check_all();
        end

        // R4: no runt phases anywhere during the whole run
        begin
            int tot;
            tot = src_u;
            for (int i = 0; i < N_CPU; i++)  tot += cpu_u[i];
            for (int i = 0; i < N_PCIF; i++) tot += pcif_u[i];
            for (int i = 0; i < N_PCI; i++)  tot += pci_u[i];
            for (int i = 0; i < N_REF; i++)  tot += ref_u[i];
            chk(tot == 0, "R4", "short phases seen", tot, 0);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(400_000);
        if (!done) begin
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad + 1);
            $finish;
        end
    end
endmodule